// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a countdown watchdog that sits on a simple 32-bit register bus with single-cycle read and write strobes. Software loads a reload value, writes a fixed key to a restart register to copy that value into the counter, and then sets a run bit in the control register. While running, the counter steps down either on every system clock cycle or on a slow tick. A prescaler divides the system clock to make the slow tick; with the default divider this is a 1 MHz timebase.

When a step finds the counter already at zero, the block raises a one-cycle expiry event. It then reloads the counter and keeps running. The expiry event can independently produce three outputs: a reset request pulse, a sticky interrupt, and an external trigger pulse. The block also drives a two-bit reset-scope code and a secondary-boot flag straight from the control register. Other logic that owns reset distribution and boot selection consumes these outputs.

Only the exact key value reloads the counter and clears the interrupt. Any other restart write has no effect, so a stray write cannot keep a hung system alive.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the control register, the reload register and the counter all read 0, and irqOut, rstReq and extTrig are low.
- R2: Register offsets are 0x00 counter (read-only, writes ignored), 0x04 reload (read/write), 0x08 restart (reads 0) and 0x0C control. Control keeps only bits 7:0, and its upper bits read 0.
- R3: A write of exactly 0x00004755 to offset 0x08 loads the reload value into the counter and restarts the prescaler phase.
- R4: Any other value written to offset 0x08 leaves the counter and the interrupt unchanged.
- R5: When control bit 0 (run) is set and bit 4 is clear, the counter decrements by one on every clock edge.
- R6: When bits 0 and 4 are both set, the counter decrements once every PRESCALE_DIV clocks. The first decrement comes PRESCALE_DIV edges after the run bit or the restart key takes effect.
- R7: A step taken while the counter is 0 is an expiry. The counter loads the reload value on that edge and keeps counting.
- R8: On an expiry edge, rstReq goes high for that cycle only if control bit 1 is set, and extTrig goes high for that cycle only if control bit 3 is set.
- R9: On an expiry with control bit 2 set, irqOut goes high and stays high until a correct restart key is written.
- R10: rstScope always equals control bits 6:5 (0 SoC, 1 full chip, 2 CPU only), and bootAlt always equals control bit 7.
- R11: With the run bit clear, the counter holds its value, the value still reads back at offset 0x00, and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe; read data is valid in the same cycle |
| busRdData | output | 32 | Read data; 0 when busRdEn is low |
| irqOut | output | 1 | Sticky expiry interrupt |
| rstReq | output | 1 | One-cycle reset request on expiry |
| rstScope | output | 2 | Reset scope code taken from the control register |
| extTrig | output | 1 | One-cycle external trigger on expiry |
| bootAlt | output | 1 | Secondary boot source select |

## Verification
A wrong counter state shows up at offset 0x00 on the next read, because the counter is visible directly. The bench compares it with the count expected from the number of clock edges since the last restart, so an off-by-one step or a missed prescaler tick is caught within a single check window. Wrong expiry gating shows on rstReq, extTrig or irqOut on the exact edge the counter reloads. A key decoder that is too loose shows one edge after a wrong-key write, as a counter that jumped back to the reload value or an interrupt that cleared.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W = 32;

  // register offsets
  localparam int unsigned OFS_COUNT  = 'h0;
  localparam int unsigned OFS_RELOAD = 'h4;
  localparam int unsigned OFS_KICK   = 'h8;
  localparam int unsigned OFS_CTRL   = 'hC;

  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_4755;

  // control bit positions
  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_RST   = 1;
  localparam int unsigned CB_IRQ   = 2;
  localparam int unsigned CB_EXT   = 3;
  localparam int unsigned CB_SLOW  = 4;
  localparam int unsigned CB_SCOPE = 5;
  localparam int unsigned CB_BOOT  = 7;
  localparam int unsigned CTRL_W   = 8;

  // strobes and configuration from register file to datapath
  typedef struct packed {
    logic kick;
    logic run;
    logic slowBase;
    logic rstEn;
    logic irqEn;
    logic extEn;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic [CNT_W-1:0]  cntVal,
  output wdStrobe_t         strb,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [1:0]        rstScope,
  output logic              bootAlt
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  reloadReg;
  logic hitCount, hitReload, hitKick, hitCtrl;

  assign hitCount  = (busAddr == ADDR_W'(OFS_COUNT));
  assign hitReload = (busAddr == ADDR_W'(OFS_RELOAD));
  assign hitKick   = (busAddr == ADDR_W'(OFS_KICK));
  assign hitCtrl   = (busAddr == ADDR_W'(OFS_CTRL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      reloadReg <= '0;
    end else if (busWrEn) begin
      if (hitReload) reloadReg <= busWrData[CNT_W-1:0];
      if (hitCtrl)   ctrlReg   <= busWrData[CTRL_W-1:0];
    end
  end

  always_comb begin
    strb          = '0;
    strb.kick     = busWrEn && hitKick && (busWrData == KICK_KEY);
    strb.run      = ctrlReg[CB_RUN];
    strb.slowBase = ctrlReg[CB_SLOW];
    strb.rstEn    = ctrlReg[CB_RST];
    strb.irqEn    = ctrlReg[CB_IRQ];
    strb.extEn    = ctrlReg[CB_EXT];
  end

  assign reloadVal = reloadReg;
  assign rstScope  = ctrlReg[CB_SCOPE +: 2];
  assign bootAlt   = ctrlReg[CB_BOOT];

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      if (hitCount)       busRdData = DATA_W'(cntVal);
      else if (hitReload) busRdData = DATA_W'(reloadReg);
      else if (hitCtrl)   busRdData = DATA_W'(ctrlReg);
    end
  end

  // R2: a write to the counter offset touches no stored register
  a_r2_count_ro: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && hitCount) |=> ($stable(reloadReg) && $stable(ctrlReg)));

  // R4: a restart write carrying any other value raises no kick
  a_r4_wrong_key: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && hitKick && busWrData[15:0] != 16'h4755) |-> !strb.kick);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned PRESCALE_DIV = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             irqOut,
  output logic             rstReq,
  output logic             extTrig
);
  localparam int unsigned PRE_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE_DIV - 1);

  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] cnt;
  logic tick, step, expire, slowRun;

  assign slowRun = strb.run && strb.slowBase;
  assign tick    = (presc == PRE_LAST);
  assign step    = strb.run && (strb.slowBase ? tick : 1'b1);
  assign expire  = step && (cnt == '0) && !strb.kick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      presc <= '0;
    else if (strb.kick || !slowRun) presc <= '0;
    else if (tick)                  presc <= '0;
    else                            presc <= presc + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (strb.kick) cnt <= reloadVal;
    else if (step)      cnt <= (cnt == '0) ? reloadVal : cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq  <= 1'b0;
      extTrig <= 1'b0;
      irqOut  <= 1'b0;
    end else begin
      rstReq  <= expire && strb.rstEn;
      extTrig <= expire && strb.extEn;
      if (strb.kick)                     irqOut <= 1'b0;
      else if (expire && strb.irqEn)     irqOut <= 1'b1;
    end
  end

  assign cntVal = cnt;

  // R5: fast timebase steps down by exactly one per clock
  a_r5_fast_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.slowBase && !strb.kick && cnt != '0)
      |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R6: slow timebase holds the count between prescaler ticks
  a_r6_slow_hold: assert property (@(posedge clk) disable iff (!rstN)
    (slowRun && !strb.kick && !tick) |=> $stable(cnt));

  // R7: an expiry reloads the counter
  a_r7_reload: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (cnt == $past(reloadVal)));

  // R9: the restart key clears the interrupt
  a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.kick |=> !irqOut);

  // R11: a stopped counter neither moves nor expires
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.kick) |=> ($stable(cnt) && !rstReq && !extTrig));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned PRESCALE_DIV = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  output logic              irqOut,
  output logic              rstReq,
  output logic [1:0]        rstScope,
  output logic              extTrig,
  output logic              bootAlt
);
  wdStrobe_t        strb;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] cntVal;

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uRegs (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData),
    .cntVal(cntVal), .strb(strb), .reloadVal(reloadVal),
    .rstScope(rstScope), .bootAlt(bootAlt)
  );

  wdog_core #(.CNT_W(CNT_W), .PRESCALE_DIV(PRESCALE_DIV)) uCore (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadVal(reloadVal),
    .cntVal(cntVal), .irqOut(irqOut), .rstReq(rstReq), .extTrig(extTrig)
  );
endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 5;
  localparam logic [31:0] KEY = 32'h0000_4755;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        irqOut, rstReq, extTrig, bootAlt;
  logic [1:0]  rstScope;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  wdog_keyed #(.ADDR_W(4), .CNT_W(32), .PRESCALE_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .irqOut(irqOut), .rstReq(rstReq), .rstScope(rstScope),
    .extTrig(extTrig), .bootAlt(bootAlt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected count n edges after a restart with reload r
  function automatic logic [31:0] expFast(logic [31:0] r, int n);
    return r - 32'(n);
  endfunction
  function automatic logic [31:0] expSlow(logic [31:0] r, int n);
    return r - 32'(n / DIV);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // starts and ends at a falling edge; one rising edge elapses
  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [3:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, r, bad;
    int k;
    void'($urandom(32'd1234));
    waitCyc(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(4'h0, rd); check("R1 count", rd, 0);
    busRead(4'hC, rd); check("R1 ctrl", rd, 0);
    busRead(4'h4, rd); check("R1 reload", rd, 0);
    check("R1 outputs", {29'd0, irqOut, rstReq, extTrig}, 0);

    // R2 register map
    busWrite(4'h4, 32'hDEAD_BEEF);
    busRead(4'h4, rd); check("R2 reload rw", rd, 32'hDEAD_BEEF);
    busWrite(4'hC, 32'hFFFF_FF20);
    busRead(4'hC, rd); check("R2 ctrl upper", rd, 32'h20);
    busRead(4'h8, rd); check("R2 kick reads 0", rd, 0);
    // R10 scope and boot levels
    check("R10 scope 1", rstScope, 1);
    busWrite(4'hC, 32'hC0);
    check("R10 scope 2", rstScope, 2);
    check("R10 boot", bootAlt, 1);

    // R3/R5/R7/R8/R9 fast mode expiry
    busWrite(4'hC, 0);
    r = 12;
    busWrite(4'h4, r);
    busWrite(4'h8, KEY);
    busRead(4'h0, rd); check("R3 key loads", rd, r);
    busWrite(4'hC, 32'h0F);
    waitCyc(5);
    busRead(4'h0, rd); check("R5 fast count", rd, expFast(r, 5));
    waitCyc(int'(r) - 5);
    busRead(4'h0, rd); check("R5 reached 0", rd, 0);
    check("R8 no early rst", rstReq, 0);
    waitCyc(1);
    busRead(4'h0, rd); check("R7 reload on expiry", rd, r);
    check("R8 rstReq pulse", rstReq, 1);
    check("R8 extTrig pulse", extTrig, 1);
    check("R9 irq set", irqOut, 1);
    waitCyc(1);
    check("R8 rstReq one cycle", rstReq, 0);
    check("R8 extTrig one cycle", extTrig, 0);
    check("R9 irq sticky", irqOut, 1);
    busRead(4'h0, rd); check("R7 keeps running", rd, r - 1);
    busWrite(4'h8, KEY ^ 32'h0001_0000);
    busRead(4'h0, rd); check("R4 wrong key count", rd, r - 2);
    check("R4 wrong key irq", irqOut, 1);
    busWrite(4'h8, KEY);
    busRead(4'h0, rd); check("R3 reload again", rd, r);
    check("R9 irq cleared", irqOut, 0);

    // random fast-mode windows with wrong keys (R3 R4 R5)
    for (int i = 0; i < 20; i++) begin
      r = $urandom_range(60, 5);
      busWrite(4'h4, r);
      busWrite(4'h8, KEY);
      k = $urandom_range(int'(r) - 2, 0);
      waitCyc(k);
      busRead(4'h0, rd); check("R5 random count", rd, expFast(r, k));
      bad = $urandom;
      if (bad == KEY) bad = bad ^ 32'h1;
      busWrite(4'h8, bad);
      busRead(4'h0, rd); check("R4 random bad key", rd, expFast(r, k + 1));
    end

    // gating: only interrupt enabled (R8 R9)
    busWrite(4'hC, 0);
    busWrite(4'h4, 3);
    busWrite(4'h8, KEY);
    busWrite(4'hC, 32'h05);
    waitCyc(4);
    busRead(4'h0, rd); check("R7 expiry reload 3", rd, 3);
    check("R9 irq gated on", irqOut, 1);
    check("R8 rstReq gated off", rstReq, 0);
    check("R8 extTrig gated off", extTrig, 0);

    // R11 freeze
    busWrite(4'hC, 0);
    busRead(4'h0, rd); check("R11 frozen value", rd, 2);
    waitCyc(10);
    busRead(4'h0, rd); check("R11 still frozen", rd, 2);
    busWrite(4'h0, 32'hFFFF);
    busRead(4'h0, rd); check("R2 count write ignored", rd, 2);
    check("R11 no rst", rstReq, 0);

    // R6 slow mode
    r = 20;
    busWrite(4'h4, r);
    busWrite(4'h8, KEY);
    busWrite(4'hC, 32'h11);
    waitCyc(DIV - 1);
    busRead(4'h0, rd); check("R6 before tick", rd, expSlow(r, DIV - 1));
    waitCyc(1);
    busRead(4'h0, rd); check("R6 first tick", rd, expSlow(r, DIV));
    waitCyc(DIV);
    busRead(4'h0, rd); check("R6 second tick", rd, expSlow(r, 2 * DIV));
    waitCyc(2);
    busWrite(4'h8, KEY);
    waitCyc(DIV - 1);
    busRead(4'h0, rd); check("R3 key restarts prescaler", rd, r);
    waitCyc(1);
    busRead(4'h0, rd); check("R6 tick after key", rd, r - 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule